// File: doc/BRIEF.md
# Affine Perspective Coordinate Mapper

This block turns every output pixel of one tile into the input-image coordinate it should be read from. It walks the tile in raster order, starting at a programmed output point. For each output point it evaluates a six-coefficient affine transform in Q12 fixed point. A projective divide can then be applied on top. Each result is presented as a pair of signed source coordinates with 4 fractional bits, for a downstream interpolator.

A tile begins with a single-cycle `start`. The coefficients, the perspective enable, the starting point and the tile size are all captured at that moment. Results are handed out through a valid/ready pair. When perspective is off, a new result is ready one cycle after the previous one is taken. When perspective is on, a serial divider stalls `outValid` while it works. A one-cycle `tileDone` pulse marks the acceptance of the tile's last result.

Top module: `affine_coord_mapper`

## Requirements
- R1: While `rstN` is low and directly after it is released, `outValid` and `tileDone` are low.
- R2: The scan visits the output point (x, y) = (initX + col, initY + row) for col 0..tileW-1 within row 0..tileH-1, with col advancing fastest. `initX` and `initY` are 13-bit unsigned. `tileW` and `tileH` are 8-bit column and row counts.
- R3: With perspective off, outX = floor((A·x + B·y + C) / 256) and outY = floor((D·x + E·y + F) / 256). This is the Q12 sum with 4 fractional bits kept, in 24-bit two's complement. A, B, D and E are 16-bit signed Q12. C and F are 32-bit signed Q12.
- R4: With A = E = 4096 and B = C = D = F = 0, perspective off, the outputs are exactly outX = 16·x and outY = 16·y.
- R5: With perspective on, let w = G·x + H·y + 4096, where G and H are 16-bit signed. Then outX = (16·(A·x + B·y + C)) / w and outY = (16·(D·x + E·y + F)) / w, with the quotient truncated toward zero. w must be nonzero.
- R6: While `outValid` is high and `outReady` is low, `outValid` stays high and `outX`/`outY` hold their values.
- R7: Take the rising edge that samples an accepted `start`, or the edge of the previous handshake. With perspective off, `outValid` is high after the 1st following edge. With perspective on, it is high after the 39th following edge. `outValid` is low until then.
- R8: `tileDone` is high for exactly one cycle, directly after the edge at which the tile's last result is accepted, and `outValid` is low in that cycle. It stays low after all other handshakes.
- R9: A `start` pulse while a tile is in progress is ignored. Changes to any configuration input after the accepted `start` do not affect the tile in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a tile when idle; captures the configuration |
| coefA | input | 16 | Signed Q12 weight of x in the source x |
| coefB | input | 16 | Signed Q12 weight of y in the source x |
| coefC | input | 32 | Signed Q12 offset of the source x |
| coefD | input | 16 | Signed Q12 weight of x in the source y |
| coefE | input | 16 | Signed Q12 weight of y in the source y |
| coefF | input | 32 | Signed Q12 offset of the source y |
| persG | input | 16 | Signed Q12 perspective weight of x |
| persH | input | 16 | Signed Q12 perspective weight of y |
| persEn | input | 1 | Enables the projective divide |
| initX | input | 13 | Output x of the tile's first pixel |
| initY | input | 13 | Output y of the tile's first pixel |
| tileW | input | 8 | Columns in the tile |
| tileH | input | 8 | Rows in the tile |
| outValid | output | 1 | A source coordinate pair is presented |
| outReady | input | 1 | Consumer takes the presented pair |
| outX | output | 24 | Signed source x, 4 fractional bits |
| outY | output | 24 | Signed source y, 4 fractional bits |
| tileDone | output | 1 | One-cycle pulse after the last pair is accepted |

## Verification
Each result is due a fixed number of edges after its trigger. The trigger is either the edge that accepts `start` or the edge of the previous handshake. A result is due 1 edge later with perspective off and 39 edges later with perspective on. The bench therefore counts falling edges from the trigger until `outValid` appears and compares that count with the figure. It compares the coordinates at the same falling edge. The hold behaviour is checked one cycle into a deliberate stall. `tileDone` is sampled at the falling edge directly after the last handshake, and again one cycle later to confirm it has dropped.

// File: rtl/apm_pkg.sv
package apm_pkg;
  localparam int QBITS = 12;

  typedef struct packed {
    logic load;  // capture tile configuration
    logic calc;  // evaluate transform for current point
  } apm_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CALC,
    ST_DIV,
    ST_OUT
  } apm_state_t;
endpackage

// File: rtl/apm_divider.sv
module apm_divider #(
  parameter int NUM_W = 37,
  parameter int DEN_W = 33
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [NUM_W-1:0] numMag,
  input  logic [DEN_W-1:0] denMag,
  output logic             busy,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem;
  logic [DEN_W-1:0] den;
  logic [NUM_W-1:0] quoR;
  logic [CNT_W-1:0] cnt;
  logic [DEN_W:0]   remShift;
  logic [DEN_W:0]   diff;

  always_comb begin
    remShift = {rem, quoR[NUM_W-1]};
    diff     = remShift - {1'b0, den};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rem  <= '0;
      den  <= '0;
      quoR <= '0;
      cnt  <= '0;
    end else if (load) begin
      rem  <= '0;
      den  <= denMag;
      quoR <= numMag;
      cnt  <= CNT_W'(NUM_W);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
      if (!diff[DEN_W]) begin
        rem  <= diff[DEN_W-1:0];
        quoR <= {quoR[NUM_W-2:0], 1'b1};
      end else begin
        rem  <= remShift[DEN_W-1:0];
        quoR <= {quoR[NUM_W-2:0], 1'b0};
      end
    end
  end

  assign busy = (cnt != '0);
  assign quo  = quoR;
endmodule

// File: rtl/apm_ctrl.sv
module apm_ctrl
  import apm_pkg::*;
#(
  parameter int PT_W  = 13,
  parameter int SZ_W  = 8,
  parameter int CRD_W = PT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [PT_W-1:0]   initX,
  input  logic [PT_W-1:0]   initY,
  input  logic [SZ_W-1:0]   tileW,
  input  logic [SZ_W-1:0]   tileH,
  input  logic              perspOn,
  input  logic              divBusy,
  input  logic              outReady,
  output apm_strobe_t       strobe,
  output logic [CRD_W-1:0]  curX,
  output logic [CRD_W-1:0]  curY,
  output logic              outValid,
  output logic              tileDone,
  output logic              scanIdle
);
  apm_state_t      state;
  logic [PT_W-1:0] ixR, iyR;
  logic [SZ_W-1:0] wR, hR, colCnt, rowCnt;
  logic            lastCol, lastRow;

  assign lastCol = (colCnt == wR - 1'b1);
  assign lastRow = (rowCnt == hR - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      ixR      <= '0;
      iyR      <= '0;
      wR       <= '0;
      hR       <= '0;
      colCnt   <= '0;
      rowCnt   <= '0;
      tileDone <= 1'b0;
    end else begin
      tileDone <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          ixR    <= initX;
          iyR    <= initY;
          wR     <= tileW;
          hR     <= tileH;
          colCnt <= '0;
          rowCnt <= '0;
          state  <= ST_CALC;
        end
        ST_CALC: state <= perspOn ? ST_DIV : ST_OUT;
        ST_DIV:  if (!divBusy) state <= ST_OUT;
        ST_OUT: if (outReady) begin
          if (lastCol) begin
            colCnt <= '0;
            if (lastRow) begin
              tileDone <= 1'b1;
              state    <= ST_IDLE;
            end else begin
              rowCnt <= rowCnt + 1'b1;
              state  <= ST_CALC;
            end
          end else begin
            colCnt <= colCnt + 1'b1;
            state  <= ST_CALC;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load = (state == ST_IDLE) && start;
    strobe.calc = (state == ST_CALC);
  end

  assign curX     = CRD_W'(ixR) + CRD_W'(colCnt);
  assign curY     = CRD_W'(iyR) + CRD_W'(rowCnt);
  assign outValid = (state == ST_OUT);
  assign scanIdle = (state == ST_IDLE);
endmodule

// File: rtl/apm_datapath.sv
module apm_datapath
  import apm_pkg::*;
#(
  parameter int COEF_W = 16,
  parameter int OFF_W  = 32,
  parameter int CRD_W  = 14,
  parameter int FRAC_W = 4,
  parameter int OUT_W  = 24
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  apm_strobe_t              strobe,
  input  logic signed [COEF_W-1:0] coefA,
  input  logic signed [COEF_W-1:0] coefB,
  input  logic signed [OFF_W-1:0]  coefC,
  input  logic signed [COEF_W-1:0] coefD,
  input  logic signed [COEF_W-1:0] coefE,
  input  logic signed [OFF_W-1:0]  coefF,
  input  logic signed [COEF_W-1:0] persG,
  input  logic signed [COEF_W-1:0] persH,
  input  logic                     persEn,
  input  logic [CRD_W-1:0]         curX,
  input  logic [CRD_W-1:0]         curY,
  output logic                     perspOn,
  output logic                     divBusy,
  output logic [OUT_W-1:0]         outX,
  output logic [OUT_W-1:0]         outY
);
  localparam int PROD_W = COEF_W + CRD_W + 1;
  localparam int SUM_W  = ((PROD_W + 1 > OFF_W) ? PROD_W + 1 : OFF_W) + 1;
  localparam int NUM_W  = SUM_W + FRAC_W;
  localparam int DEN_W  = PROD_W + 2;
  localparam int SHIFT  = QBITS - FRAC_W;

  logic signed [COEF_W-1:0] wX [2];
  logic signed [COEF_W-1:0] wY [2];
  logic signed [OFF_W-1:0]  wO [2];
  logic signed [COEF_W-1:0] gR, hR;
  logic                     perspR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wX[0] <= '0; wY[0] <= '0; wO[0] <= '0;
      wX[1] <= '0; wY[1] <= '0; wO[1] <= '0;
      gR <= '0; hR <= '0; perspR <= 1'b0;
    end else if (strobe.load) begin
      wX[0] <= coefA; wY[0] <= coefB; wO[0] <= coefC;
      wX[1] <= coefD; wY[1] <= coefE; wO[1] <= coefF;
      gR <= persG; hR <= persH; perspR <= persEn;
    end
  end

  logic signed [CRD_W:0]   xs, ys;
  logic signed [DEN_W-1:0] wSum;
  logic [DEN_W-1:0]        denMag;
  logic [OUT_W-1:0]        res  [2];
  logic                    busyV[2];

  assign xs = $signed({1'b0, curX});
  assign ys = $signed({1'b0, curY});
  assign wSum = DEN_W'(gR) * DEN_W'(xs) + DEN_W'(hR) * DEN_W'(ys)
              + DEN_W'(1 << QBITS);
  assign denMag = wSum[DEN_W-1] ? DEN_W'(-wSum) : DEN_W'(wSum);

  for (genvar k = 0; k < 2; k++) begin : g_axis
    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] shifted;
    logic signed [NUM_W-1:0] num;
    logic [NUM_W-1:0]        numMag;
    logic [NUM_W-1:0]        quo;
    logic [NUM_W-1:0]        quoSigned;
    logic [OUT_W-1:0]        affR;
    logic                    negR;

    assign sum = SUM_W'(wX[k]) * SUM_W'(xs) + SUM_W'(wY[k]) * SUM_W'(ys)
               + SUM_W'(wO[k]);
    assign shifted = sum >>> SHIFT;
    assign num     = {sum, {FRAC_W{1'b0}}};
    assign numMag  = num[NUM_W-1] ? NUM_W'(-num) : NUM_W'(num);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        affR <= '0;
        negR <= 1'b0;
      end else if (strobe.calc) begin
        affR <= OUT_W'(shifted);
        negR <= num[NUM_W-1] ^ wSum[DEN_W-1];
      end
    end

    apm_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) uDiv (
      .clk    (clk),
      .rstN   (rstN),
      .load   (strobe.calc && perspR),
      .numMag (numMag),
      .denMag (denMag),
      .busy   (busyV[k]),
      .quo    (quo)
    );

    assign quoSigned = negR ? (~quo + 1'b1) : quo;
    assign res[k]    = perspR ? OUT_W'(quoSigned) : affR;
  end

  assign outX    = res[0];
  assign outY    = res[1];
  assign divBusy = busyV[0] | busyV[1];
  assign perspOn = perspR;
endmodule

// File: rtl/affine_coord_mapper.sv
module affine_coord_mapper
  import apm_pkg::*;
#(
  parameter int COEF_W = 16,
  parameter int OFF_W  = 32,
  parameter int PT_W   = 13,
  parameter int SZ_W   = 8,
  parameter int FRAC_W = 4,
  parameter int OUT_W  = 24
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic signed [COEF_W-1:0] coefA,
  input  logic signed [COEF_W-1:0] coefB,
  input  logic signed [OFF_W-1:0]  coefC,
  input  logic signed [COEF_W-1:0] coefD,
  input  logic signed [COEF_W-1:0] coefE,
  input  logic signed [OFF_W-1:0]  coefF,
  input  logic signed [COEF_W-1:0] persG,
  input  logic signed [COEF_W-1:0] persH,
  input  logic                     persEn,
  input  logic [PT_W-1:0]          initX,
  input  logic [PT_W-1:0]          initY,
  input  logic [SZ_W-1:0]          tileW,
  input  logic [SZ_W-1:0]          tileH,
  output logic                     outValid,
  input  logic                     outReady,
  output logic [OUT_W-1:0]         outX,
  output logic [OUT_W-1:0]         outY,
  output logic                     tileDone
);
  localparam int CRD_W = PT_W + 1;

  apm_strobe_t      strobe;
  logic [CRD_W-1:0] curX, curY;
  logic             perspOn, divBusy, scanIdle;

  apm_ctrl #(.PT_W(PT_W), .SZ_W(SZ_W), .CRD_W(CRD_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .initX    (initX),
    .initY    (initY),
    .tileW    (tileW),
    .tileH    (tileH),
    .perspOn  (perspOn),
    .divBusy  (divBusy),
    .outReady (outReady),
    .strobe   (strobe),
    .curX     (curX),
    .curY     (curY),
    .outValid (outValid),
    .tileDone (tileDone),
    .scanIdle (scanIdle)
  );

  apm_datapath #(
    .COEF_W(COEF_W), .OFF_W(OFF_W), .CRD_W(CRD_W),
    .FRAC_W(FRAC_W), .OUT_W(OUT_W)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .coefA   (coefA),
    .coefB   (coefB),
    .coefC   (coefC),
    .coefD   (coefD),
    .coefE   (coefE),
    .coefF   (coefF),
    .persG   (persG),
    .persH   (persH),
    .persEn  (persEn),
    .curX    (curX),
    .curY    (curY),
    .perspOn (perspOn),
    .divBusy (divBusy),
    .outX    (outX),
    .outY    (outY)
  );
endmodule

// File: rtl/affine_coord_mapper_chk.sv
module affine_coord_mapper_chk #(
  parameter int OUT_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             persEn,
  input logic             scanIdle,
  input logic             outValid,
  input logic             outReady,
  input logic [OUT_W-1:0] outX,
  input logic [OUT_W-1:0] outY,
  input logic             tileDone
);
  a_r6_hold_under_stall: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outX) && $stable(outY));

  a_r7_affine_latency: assert property (@(posedge clk) disable iff (!rstN)
    start && scanIdle && !persEn |=> !outValid ##1 outValid);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    tileDone |=> !tileDone);

  a_r8_done_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    tileDone |-> $past(outValid && outReady));

  a_r8_done_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    tileDone |-> !outValid);

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rstN |=> !outValid && !tileDone);
endmodule

bind affine_coord_mapper affine_coord_mapper_chk #(.OUT_W(OUT_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .persEn   (persEn),
  .scanIdle (scanIdle),
  .outValid (outValid),
  .outReady (outReady),
  .outX     (outX),
  .outY     (outY),
  .tileDone (tileDone)
);

// File: tb/tb_affine_coord_mapper.sv
module tb_affine_coord_mapper;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic signed [15:0] cA, cB, cD, cE, cG, cH;
  logic signed [31:0] cC, cF;
  logic cEn;
  logic [12:0] cIX, cIY;
  logic [7:0] tileWd, tileHt;
  logic outValid, outReady, tileDone;
  logic [23:0] outX, outY;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  affine_coord_mapper dut (
    .clk(clk), .rstN(rstN), .start(start),
    .coefA(cA), .coefB(cB), .coefC(cC), .coefD(cD), .coefE(cE), .coefF(cF),
    .persG(cG), .persH(cH), .persEn(cEn),
    .initX(cIX), .initY(cIY), .tileW(tileWd), .tileH(tileHt),
    .outValid(outValid), .outReady(outReady),
    .outX(outX), .outY(outY), .tileDone(tileDone)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint mapAxis(input longint p, input longint q, input longint o,
                                     input longint g, input longint h, input bit en,
                                     input longint x, input longint y);
    longint s = p * x + q * y + o;
    longint w;
    if (!en) return s >>> 8;
    w = g * x + h * y + 4096;
    return (s * 16) / w;
  endfunction

  task automatic setCfg(input int a, b, c, d, e, f, g, h, input bit en,
                        input int ix, iy, w, ht);
    cA = 16'(a); cB = 16'(b); cC = 32'(c); cD = 16'(d); cE = 16'(e); cF = 32'(f);
    cG = 16'(g); cH = 16'(h); cEn = en;
    cIX = 13'(ix); cIY = 13'(iy); tileWd = 8'(w); tileHt = 8'(ht);
  endtask

  // One tile: raster order (R2), values (tag), latency (R7), stall hold (R6), done (R8)
  task automatic runTile(input bit stall, input bit disturb, input string tag);
    longint la = cA, lb = cB, lc = cC, ld = cD, le = cE, lf = cF, lg = cG, lh = cH;
    bit len = cEn;
    int ix = cIX, iy = cIY, w = tileWd, ht = tileHt;
    int expLat = len ? 39 : 1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int r = 0; r < ht; r++) begin
      for (int c = 0; c < w; c++) begin
        int n = 0;
        longint ex, ey;
        bit last = (r == ht - 1) && (c == w - 1);
        while (!outValid && n < 300) begin
          @(negedge clk);
          start = 1'b0;
          n++;
        end
        ex = mapAxis(la, lb, lc, lg, lh, len, ix + c, iy + r);
        ey = mapAxis(ld, le, lf, lg, lh, len, ix + c, iy + r);
        chk(n == expLat, "R7 latency", n, expLat);
        chk(longint'($signed(outX)) == ex, {tag, " outX"}, longint'($signed(outX)), ex);
        chk(longint'($signed(outY)) == ey, {tag, " outY"}, longint'($signed(outY)), ey);
        if (stall && ((r * w + c) % 2 == 0)) begin
          outReady = 1'b0;
          @(negedge clk);
          chk(outValid == 1'b1, "R6 valid held", outValid, 1);
          chk(longint'($signed(outX)) == ex && longint'($signed(outY)) == ey,
              "R6 value held", longint'($signed(outX)), ex);
        end
        outReady = 1'b1;
        @(negedge clk);
        outReady = 1'b0;
        if (last) begin
          chk(tileDone == 1'b1, "R8 done pulse", tileDone, 1);
          chk(outValid == 1'b0, "R8 valid low with done", outValid, 0);
        end else begin
          chk(tileDone == 1'b0, "R8 no early done", tileDone, 0);
        end
        if (disturb && r == 0 && c == 0) begin
          // R9: retrigger and reprogram mid-tile; must be ignored
          start = 1'b1;
          setCfg(1, 2, 3, 4, 5, 6, 7, 8, !len, 9, 9, 1, 1);
        end
      end
    end
    @(negedge clk);
    chk(tileDone == 1'b0, "R8 done one cycle", tileDone, 0);
  endtask

  initial begin
    outReady = 1'b0;
    setCfg(4096, 0, 0, 0, 4096, 0, 0, 0, 0, 0, 0, 1, 1);
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R1 valid in reset", outValid, 0);
    chk(tileDone == 1'b0, "R1 done in reset", tileDone, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0 && tileDone == 1'b0, "R1 idle after reset", outValid, 0);

    // R4 identity, R2 raster over a 4x3 tile
    setCfg(4096, 0, 0, 0, 4096, 0, 0, 0, 0, 3, 7, 4, 3);
    runTile(0, 0, "R4");
    // R4 at the top of the coordinate range
    setCfg(4096, 0, 0, 0, 4096, 0, 0, 0, 0, 8190, 8190, 2, 1);
    runTile(1, 0, "R4");
    // R3 general affine with negative terms, with stalls
    setCfg(4000, -300, -5000, 250, 4200, 123456, 0, 0, 0, 100, 50, 5, 4);
    runTile(1, 0, "R3");
    // R3 negative outputs, floor rounding
    setCfg(-4096, 77, -101, 33, -4096, -3333, 0, 0, 0, 17, 29, 3, 2);
    runTile(0, 0, "R3");
    // R2 single-pixel tile
    setCfg(4096, 100, 200, -50, 4096, 300, 0, 0, 0, 11, 12, 1, 1);
    runTile(0, 0, "R2");
    // R5 perspective, positive numerators
    setCfg(4000, -300, -5000, 250, 4200, 123456, 20, -15, 1, 10, 20, 3, 3);
    runTile(1, 0, "R5");
    // R5 perspective, negative numerators
    setCfg(-4096, 100, -7777, 50, -4096, 9999, -40, 10, 1, 5, 5, 2, 2);
    runTile(0, 0, "R5");
    // R9 start and configuration changes during a tile
    setCfg(4000, -300, -5000, 250, 4200, 123456, 0, 0, 0, 40, 60, 3, 2);
    runTile(0, 1, "R9");
    setCfg(3000, 500, 800, -200, 4096, 0, 30, 5, 1, 2, 3, 2, 2);
    runTile(1, 1, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule